// File: doc/BRIEF.md
# Two-Wire Register Slave with Byte and Block Access

This block is a slave on a two-wire serial bus compatible with I2C and SMBus, using 7-bit addressing at standard (100 kbit/s) and fast (400 kbit/s) rates. It gives a bus host read and write access to a register file of up to 128 bytes. SCL and SDA are sampled by a much faster system clock through two-stage synchronisers. SDA is driven open-drain: the block only raises an output enable that pulls the line low.

After its address, the host sends a command byte. Bit 7 of that byte chooses single-byte access (1) or sequential block access (0). Bits 6:0 give the starting register offset. Write data bytes go straight into the register file through a one-cycle write strobe. Reads use a repeated START followed by the address with R/W set, and begin at the stored offset. A block read returns as many bytes as a byte-count input says. A single-byte read returns exactly one byte.

The register file side is a plain combinational read port and a strobed write port. A busy input, raised while a nonvolatile commit runs, blocks writes but leaves reads working.

Top module: `twi_reg_slave`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal `{5'b11001, addr_lsb}` (A6 first). With `addr_lsb` = 00 the address is 7'h64. Any other address gets no acknowledge and the block stays off the bus.
- R2: The command byte is always acknowledged. Its bit 7 selects single-byte mode (1) or block mode (0), and its bits 6:0 set the register offset.
- R3: In block mode, successive write data bytes go to ascending offsets, starting at the commanded offset. The host may stop after any complete byte.
- R4: In single-byte mode, only the first write data byte is accepted. Any further data byte in the same transfer is not acknowledged and changes no register.
- R5: A block read sends the registers from the stored offset upward, `blk_count` bytes in all. Every byte after that, and every byte when `blk_count` is 0, reads 0xFF. Bytes go MSB first.
- R6: A single-byte read sends the register at the stored offset. If the host acknowledges it, the following bytes read 0xFF.
- R7: Each accepted write byte reaches the register file, through a strobe lasting one system cycle, before the acknowledge clock pulse ends. A following byte in the same transfer therefore sees it.
- R8: While `commit_busy` is high at the acknowledge decision of a write data byte, that byte is not acknowledged and is not written. Reads are served normally while busy.
- R9: A read phase starts at the offset left by the previous access. A block read leaves the offset just past its last counted byte. A single-byte access leaves the offset unchanged.
- R10: A START or STOP seen in the middle of a byte abandons the transfer. After a STOP the block is idle and releases SDA. After a START it expects an address.
- R11: The SDA enable rises only while the synchronised SCL is low. SDA driven by the block stays stable during each SCL high phase.
- R12: After reset the block releases SDA and issues no write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | High pulls SDA low (open-drain drive) |
| addr_lsb | input | 2 | Low two bits of the slave address, from a register |
| blk_count | input | CNT_W | Number of bytes returned by a block read |
| commit_busy | input | 1 | Nonvolatile commit in progress; writes are refused |
| reg_addr | output | OFS_W | Register file offset for read and write |
| reg_wdata | output | 8 | Write data to the register file |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Combinational read data at `reg_addr` |

## Verification
Two events can fall in the same cycle: the acknowledge decision for a write data byte and a change of the commit-busy input. To provoke this, the bench toggles `commit_busy` at the very instant it drops SCL after the eighth data bit, so the new level settles only the synchroniser latency before the decision. When busy rises there, the bench expects a missing acknowledge and an unchanged register. When busy falls there, it expects an acknowledge and the written value in the register file. Both outcomes are compared against a register image kept by the bench.

// File: rtl/twi_reg_slave.sv
module twi_reg_slave #(
  parameter logic [4:0] DEV_HI = 5'b11001,
  parameter int OFS_W = 7,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [1:0]       addr_lsb,
  input  logic [CNT_W-1:0] blk_count,
  input  logic             commit_busy,
  output logic [OFS_W-1:0] reg_addr,
  output logic [7:0]       reg_wdata,
  output logic             reg_we,
  input  logic [7:0]       reg_rdata
);
  localparam int DW = 8;
  localparam int BC_W = $clog2(DW + 1);
  localparam logic [BC_W-1:0] LAST = BC_W'(DW);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_WR, S_ACK, S_RD, S_RACK, S_HOLD} st_t;

  st_t state, after;
  logic [2:0] scl_p, sda_p;
  logic [BC_W-1:0] cnt;
  logic [DW-1:0] sh;
  logic [OFS_W-1:0] ptr;
  logic [CNT_W-1:0] rd_left;
  logic single, wr_done;

  logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c, do_load, st_idle;

  assign scl_s    = scl_p[1];
  assign sda_s    = sda_p[1];
  assign scl_rise = scl_p[1] & ~scl_p[2];
  assign scl_fall = ~scl_p[1] & scl_p[2];
  assign start_c  = scl_p[1] & scl_p[2] & sda_p[2] & ~sda_p[1];
  assign stop_c   = scl_p[1] & scl_p[2] & ~sda_p[2] & sda_p[1];
  assign do_load  = scl_fall && ((state == S_ACK && after == S_RD) || state == S_RACK);
  assign st_idle  = (state == S_IDLE);

  assign reg_addr  = ptr;
  assign reg_wdata = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      after   <= S_IDLE;
      cnt     <= '0;
      sh      <= '0;
      ptr     <= '0;
      rd_left <= '0;
      single  <= 1'b0;
      wr_done <= 1'b0;
      sda_oe  <= 1'b0;
      reg_we  <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      if (reg_we && !single) ptr <= ptr + 1'b1;
      if (start_c) begin
        state  <= S_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          S_ADDR, S_CMD, S_WR: begin
            if (scl_rise && cnt != LAST) begin
              sh  <= {sh[DW-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST) begin
              if (state == S_ADDR) begin
                if (sh[DW-1:1] == {DEV_HI, addr_lsb}) begin
                  sda_oe  <= 1'b1;
                  state   <= S_ACK;
                  after   <= sh[0] ? S_RD : S_CMD;
                  rd_left <= single ? CNT_W'(1) : blk_count;
                end else begin
                  state <= S_IDLE;
                end
              end else if (state == S_CMD) begin
                single  <= sh[DW-1];
                ptr     <= sh[OFS_W-1:0];
                wr_done <= 1'b0;
                sda_oe  <= 1'b1;
                state   <= S_ACK;
                after   <= S_WR;
              end else if (!commit_busy && !(single && wr_done)) begin
                sda_oe  <= 1'b1;
                reg_we  <= 1'b1;
                wr_done <= 1'b1;
                state   <= S_ACK;
                after   <= S_WR;
              end else begin
                state <= S_HOLD;
              end
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              state  <= after;
            end
          end
          S_RD: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == LAST) begin
                sda_oe <= 1'b0;
                state  <= S_RACK;
              end else begin
                sh     <= {sh[DW-2:0], 1'b1};
                sda_oe <= ~sh[DW-2];
              end
            end
          end
          S_RACK: begin
            if (scl_rise && sda_s) state <= S_HOLD;
            else if (scl_fall) begin
              cnt   <= '0;
              state <= S_RD;
            end
          end
          default: ;
        endcase
        if (do_load) begin
          if (rd_left != '0) begin
            sh      <= reg_rdata;
            sda_oe  <= ~reg_rdata[DW-1];
            rd_left <= rd_left - 1'b1;
            if (!single) ptr <= ptr + 1'b1;
          end else begin
            sh     <= '1;
            sda_oe <= 1'b0;
          end
        end
      end
    end
  end
endmodule

module twi_reg_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic reg_we,
  input logic commit_busy,
  input logic scl_sync,
  input logic st_idle
);
  p_we_unbusy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !$past(commit_busy));
  p_we_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  p_idle_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle |-> !sda_oe);
  p_oe_rise_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_sync);
endmodule

bind twi_reg_slave twi_reg_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .reg_we(reg_we),
  .commit_busy(commit_busy), .scl_sync(scl_s), .st_idle(st_idle)
);

// File: tb/test_twi_reg_slave.sv
module test_twi_reg_slave;
  localparam int Q = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_h = 1'b1, sda_h = 1'b1;
  logic sda_oe, reg_we, commit_busy = 1'b0;
  logic [1:0] addr_lsb = 2'b00;
  logic [6:0] blk_count = 7'd5;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic sda_w;
  logic [7:0] mem [128];
  logic [7:0] exp_m [128];
  logic [7:0] rd [16];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  assign sda_w = sda_h & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  always @(posedge clk or negedge rst_n)
    if (!rst_n) for (int i = 0; i < 128; i++) mem[i] <= 8'((i * 29 + 3) & 8'hFF);
    else if (reg_we) mem[reg_addr] <= reg_wdata;

  twi_reg_slave i_twi_reg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_w), .sda_oe(sda_oe),
    .addr_lsb(addr_lsb), .blk_count(blk_count), .commit_busy(commit_busy),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata));

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic cmp_mem(input string req);
    int bad = -1;
    for (int i = 0; i < 128; i++) if (bad < 0 && mem[i] !== exp_m[i]) bad = i;
    if (bad < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, req, int'(mem[bad]), int'(exp_m[bad]));
  endtask

  task automatic qw(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_h = 1; qw(); scl_h = 1; qw(); sda_h = 0; qw(); scl_h = 0; qw();
  endtask

  task automatic bus_stop;
    sda_h = 0; qw(); scl_h = 1; qw(); sda_h = 1; qw();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_h = b[i]; qw(); scl_h = 1; qw(2); scl_h = 0; qw();
    end
  endtask

  task automatic tx_byte(input logic [7:0] b, input int bz, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; qw(); scl_h = 1; qw(2); scl_h = 0;
      if (i == 0 && bz >= 0) commit_busy = bz[0];
      qw();
    end
    sda_h = 1; qw(); scl_h = 1; qw(); ack = !sda_w; qw(); scl_h = 0; qw();
  endtask

  task automatic rx_byte(input logic host_ack, output logic [7:0] b);
    logic early;
    for (int i = 7; i >= 0; i--) begin
      sda_h = 1; qw(); scl_h = 1; early = sda_w; qw(); b[i] = sda_w;
      chk(early === b[i], "R11 sda stable while scl high", int'(b[i]), int'(early));
      qw(); scl_h = 0; qw();
    end
    sda_h = !host_ack; qw(); scl_h = 1; qw(2); scl_h = 0; qw(); sda_h = 1;
  endtask

  task automatic write_seq(input logic [7:0] cmd, input int n, input logic [7:0] d0,
                           output logic [15:0] ackv);
    logic a;
    ackv = '0;
    bus_start;
    tx_byte({7'h64 | {5'b0, addr_lsb}, 1'b0}, -1, a);
    tx_byte(cmd, -1, a);
    for (int i = 0; i < n; i++) begin
      tx_byte(d0 + 8'(i), -1, a);
      ackv[i] = a;
    end
    bus_stop;
  endtask

  task automatic read_phase(input int n);
    logic a;
    tx_byte({7'h64 | {5'b0, addr_lsb}, 1'b1}, -1, a);
    chk(a, "R9 read address ack", int'(a), 1);
    for (int i = 0; i < n; i++) rx_byte(i != n - 1, rd[i]);
    bus_stop;
  endtask

  task automatic read_seq(input logic [7:0] cmd, input int n);
    logic a;
    bus_start;
    tx_byte({7'h64 | {5'b0, addr_lsb}, 1'b0}, -1, a);
    tx_byte(cmd, -1, a);
    chk(a, "R2 command ack", int'(a), 1);
    bus_start;
    read_phase(n);
  endtask

  initial begin
    logic a;
    logic [15:0] av;
    for (int i = 0; i < 128; i++) exp_m[i] = 8'((i * 29 + 3) & 8'hFF);
    repeat (3) @(negedge clk);
    chk(sda_oe === 1'b0 && reg_we === 1'b0, "R12 reset released", int'({sda_oe, reg_we}), 0);
    rst_n = 1'b1;
    qw(2);

    // R1: sweep all addresses with addr_lsb = 10
    addr_lsb = 2'b10;
    for (int ad = 0; ad < 128; ad++) begin
      bus_start; tx_byte({7'(ad), 1'b0}, -1, a); bus_stop;
      chk(a == (ad == 7'h66), "R1 address match", int'(a), int'(ad == 7'h66));
    end
    for (int l = 0; l < 4; l++) begin
      addr_lsb = 2'(l);
      bus_start; tx_byte({7'h64 | 7'(l), 1'b0}, -1, a); bus_stop;
      chk(a, "R1 programmed low bits", int'(a), 1);
      bus_start; tx_byte({7'h64 | 7'(l ^ 1), 1'b0}, -1, a); bus_stop;
      chk(!a, "R1 other low bits", int'(a), 0);
    end
    addr_lsb = 2'b00;
    cmp_mem("R1 no writes during sweep");

    // R3 block write
    write_seq(8'h10, 4, 8'hA0, av);
    for (int i = 0; i < 4; i++) exp_m[16 + i] = 8'hA0 + 8'(i);
    chk(av[3:0] == 4'hF, "R3 block write acks", int'(av[3:0]), 15);
    cmp_mem("R3 ascending block write");

    // R4 single-byte write, second byte refused
    write_seq(8'h85, 2, 8'h5A, av);
    exp_m[5] = 8'h5A;
    chk(av[1:0] == 2'b01, "R4 second byte nacked", int'(av[1:0]), 1);
    cmp_mem("R4 only one byte written");

    // R7 write visible before next byte
    bus_start;
    tx_byte(8'hC8, -1, a); tx_byte(8'h30, -1, a);
    tx_byte(8'h11, -1, a);
    chk(mem[48] == 8'h11, "R7 immediate write", int'(mem[48]), 8'h11);
    tx_byte(8'h22, -1, a);
    chk(mem[49] == 8'h22, "R7 immediate write next", int'(mem[49]), 8'h22);
    bus_stop;
    exp_m[48] = 8'h11; exp_m[49] = 8'h22;

    // R5 block read with count 5
    read_seq(8'h10, 7);
    for (int i = 0; i < 7; i++) begin
      logic [7:0] e;
      e = (i < 5) ? exp_m[16 + i] : 8'hFF;
      chk(rd[i] == e, "R5 block read data", int'(rd[i]), int'(e));
    end
    // R9 stored offset advanced past the counted bytes
    bus_start; read_phase(1);
    chk(rd[0] == exp_m[21], "R9 offset after block read", int'(rd[0]), int'(exp_m[21]));
    blk_count = 7'd0;
    read_seq(8'h10, 2);
    chk(rd[0] == 8'hFF && rd[1] == 8'hFF, "R5 zero count", int'({rd[0], rd[1]}), 16'hFFFF);
    blk_count = 7'd5;

    // R6 single-byte read then 0xFF
    read_seq(8'h85, 2);
    chk(rd[0] == exp_m[5], "R6 byte read", int'(rd[0]), int'(exp_m[5]));
    chk(rd[1] == 8'hFF, "R6 extra byte", int'(rd[1]), 8'hFF);
    bus_start; read_phase(1);
    chk(rd[0] == exp_m[5], "R9 offset kept in byte mode", int'(rd[0]), int'(exp_m[5]));

    // R8 busy blocks writes, not reads
    commit_busy = 1'b1;
    write_seq(8'h90, 1, 8'h77, av);
    chk(av[0] == 1'b0, "R8 write nacked while busy", int'(av[0]), 0);
    cmp_mem("R8 no write while busy");
    read_seq(8'h90, 1);
    chk(rd[0] == exp_m[16], "R8 read while busy", int'(rd[0]), int'(exp_m[16]));
    commit_busy = 1'b0;
    // R8 busy change at the acknowledge decision
    bus_start; tx_byte(8'hC8, -1, a); tx_byte(8'h40, -1, a);
    tx_byte(8'h99, 1, a); bus_stop;
    chk(!a, "R8 busy rising at decision", int'(a), 0);
    cmp_mem("R8 busy rising no write");
    bus_start; tx_byte(8'hC8, -1, a); tx_byte(8'h41, -1, a);
    tx_byte(8'h98, 0, a); bus_stop;
    exp_m[65] = 8'h98;
    chk(a, "R8 busy falling at decision", int'(a), 1);
    cmp_mem("R8 busy falling write");

    // R10 START in mid-byte, then full transfer
    bus_start; send_bits(8'hC8, 4);
    bus_start; tx_byte(8'hC8, -1, a);
    chk(a, "R10 restart after partial byte", int'(a), 1);
    tx_byte(8'h86, -1, a); tx_byte(8'h3C, -1, a); bus_stop;
    exp_m[6] = 8'h3C;
    cmp_mem("R10 transfer after restart");
    // R10 STOP in mid-byte
    bus_start; tx_byte(8'hC8, -1, a); tx_byte(8'h87, -1, a);
    send_bits(8'hE1, 3); scl_h = 0; bus_stop;
    chk(sda_oe == 1'b0, "R10 released after stop", int'(sda_oe), 0);
    cmp_mem("R10 no write after stop");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule